// File: doc/BRIEF.md
# Master Timing Reference Mode and Holdover Controller

This block sits beside the digital loop of a master timing generator and decides which frequency-correction word the oscillator gets. Software programs a 3-bit mode code through a write strobe. The block turns that code into one of three effective modes:

- Normal: the loop's own correction word passes through.
- Holdover: a stored copy of the loop word is applied.
- Free run: a fixed nominal word is applied.

Two of the codes arm an automatic fallback. When the loop reports loss of lock, the block leaves Normal on its own. It then stays in the fallback mode until software writes a Normal-class code again.

While the block is in Normal, it stores the loop word once per long capture interval. The default interval is sized for 128 ms. A parameter scales it down for short runs. A capture is skipped when the loop is out of lock at that instant.

A hitless change of reference is done in three steps:

1. Software enters Holdover.
2. Software swaps the reference outside this block.
3. Software returns to Normal.

After step 3 the capture interval starts again from zero.

A separate role controller tracks whether this master is primary or secondary. In manual role mode the role follows a request input. In automatic role mode a secondary master promotes itself to primary when its reference set reports an error, and it raises a one-cycle flag when it does. Once automatic, it can only go back to secondary through manual mode.

Top module: `mref_holdover_ctrl`

## Requirements
- R1: After reset the effective mode is Normal, `freq_out` equals `freq_in`, `is_primary` and `promote` are 0, and the stored holdover word is 0.
- R2: A write (`mode_wr` high at a clock edge) of code 3'b010 gives Holdover, 3'b011 gives Free run, and 3'b000 gives Normal. The reserved codes 3'b001, 3'b100 and 3'b101 act as Normal. The new mode shows on `eff_mode` right after that edge. The `eff_mode` encoding is 0 Normal, 1 Holdover, 2 Free run.
- R3: With code 3'b110 or 3'b111 the mode is Normal until `lock_err` is sampled high at an edge. From that edge on, 3'b110 gives Holdover and 3'b111 gives Free run. With an explicit 3'b000, `lock_err` has no effect on the mode.
- R4: Once an automatic fallback has occurred, it persists after `lock_err` clears. It also persists across writes of non-Normal codes: writing 3'b110 or 3'b111 again still gives the fallback mode. Only a write of 3'b000, 3'b001, 3'b100 or 3'b101 clears it.
- R5: While in Normal, an interval counter advances every clock. At the edge on which it completes HOLD_PERIOD cycles, `freq_in` is stored, unless `lock_err` is high at that edge, in which case the stored word is kept. Outside Normal the counter is held at zero and nothing is stored.
- R6: `freq_out` is `freq_in` in Normal, the stored word in Holdover, and FREE_WORD in Free run. In Holdover it does not follow `freq_in`.
- R7: With `role_auto` high, a secondary that samples `ref_err` high becomes primary at that edge, and `promote` is high for exactly the following cycle.
- R8: With `role_auto` low, `is_primary` takes `role_primary_req` at each edge. With `role_auto` high, `role_primary_req` is ignored and a primary never returns to secondary.
- R9: After a return from Holdover to Normal, the first capture happens exactly HOLD_PERIOD edges after the return write, and not one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Strobe that loads `mode_code` |
| mode_code | input | 3 | Programmed mode code |
| lock_err | input | 1 | Loop out of lock with its reference |
| freq_in | input | FREQ_W | Correction word from the loop |
| role_auto | input | 1 | 1: automatic role, 0: manual role |
| role_primary_req | input | 1 | Manual role request, 1 = primary |
| ref_err | input | 1 | Error on the reference signal set |
| eff_mode | output | 2 | Effective mode: 0 Normal, 1 Holdover, 2 Free run |
| freq_out | output | FREQ_W | Correction word to apply |
| is_primary | output | 1 | Current role, 1 = primary |
| promote | output | 1 | One-cycle flag on automatic promotion |

## Verification
Mode, role and stored-word changes all land on the clock edge that samples the stimulus. In the default build `freq_out` is a mux of registered state and `freq_in`, so every result is due in the cycle right after that edge.

The driver applies inputs on the falling edge and queues the expected outputs for the next rising edge. The monitor compares one time unit after that rising edge, so exactly one register stage separates each stimulus from its check.

The capture interval is counted edge by edge in the bench model. This lets the R5 and R9 checks place a read-back exactly on, or one edge before, a capture.

// File: rtl/mref_pkg.sv
package mref_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_HOLD   = 2'd1,
      MODE_FREE   = 2'd2
   } eff_mode_t;

   localparam logic [2:0] CODE_NORMAL    = 3'b000;
   localparam logic [2:0] CODE_HOLD      = 3'b010;
   localparam logic [2:0] CODE_FREE      = 3'b011;
   localparam logic [2:0] CODE_AUTO_HOLD = 3'b110;
   localparam logic [2:0] CODE_AUTO_FREE = 3'b111;

   // Normal plus every reserved code: a write of one of these re-arms fallback.
   function automatic logic code_is_normal(input logic [2:0] code);
      return (code == 3'b000) || (code == 3'b001) ||
             (code == 3'b100) || (code == 3'b101);
   endfunction

   function automatic logic code_is_auto(input logic [2:0] code);
      return code[2] & code[1];
   endfunction

   function automatic eff_mode_t resolve_mode(input logic [2:0] code,
                                              input logic       fallen);
      eff_mode_t m;
      case (code)
         CODE_HOLD:      m = MODE_HOLD;
         CODE_FREE:      m = MODE_FREE;
         CODE_AUTO_HOLD: m = fallen ? MODE_HOLD : MODE_NORMAL;
         CODE_AUTO_FREE: m = fallen ? MODE_FREE : MODE_NORMAL;
         default:        m = MODE_NORMAL;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/mref_mode_reg.sv
module mref_mode_reg
   import mref_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [2:0] mode_code,
   input  logic       lock_err,
   output eff_mode_t  eff_mode
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [2:0] prog_q;
   logic       fallen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q   <= CODE_NORMAL;
         fallen_q <= 1'b0;
      end else if (mode_wr) begin
         prog_q <= mode_code;
         if (code_is_normal(mode_code))
            fallen_q <= 1'b0;
      end else if (code_is_auto(prog_q) && lock_err) begin
         fallen_q <= 1'b1;
      end
   end

   assign eff_mode = resolve_mode(prog_q, fallen_q);
endmodule

// File: rtl/mref_hold_store.sv
module mref_hold_store #(
   parameter int FREQ_W      = 24,
   parameter int HOLD_PERIOD = 16_384_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en,
   input  logic              lock_err,
   input  logic [FREQ_W-1:0] freq_in,
   output logic [FREQ_W-1:0] hold_word
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CNT_W = (HOLD_PERIOD > 1) ? $clog2(HOLD_PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_PERIOD - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [FREQ_W-1:0] hold_q;
   logic              at_last;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!count_en || at_last)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (count_en && at_last && !lock_err)
         hold_q <= freq_in;
   end

   assign hold_word = hold_q;
endmodule

// File: rtl/mref_role_ctrl.sv
module mref_role_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic role_auto,
   input  logic role_primary_req,
   input  logic ref_err,
   output logic is_primary,
   output logic promote
);
   timeunit 1ns;
   timeprecision 100ps;

   logic prim_q;
   logic prom_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prim_q <= 1'b0;
         prom_q <= 1'b0;
      end else if (!role_auto) begin
         prim_q <= role_primary_req;
         prom_q <= 1'b0;
      end else if (!prim_q && ref_err) begin
         prim_q <= 1'b1;
         prom_q <= 1'b1;
      end else begin
         prom_q <= 1'b0;
      end
   end

   assign is_primary = prim_q;
   assign promote    = prom_q;
endmodule

// File: rtl/mref_holdover_ctrl.sv
module mref_holdover_ctrl
   import mref_pkg::*;
#(
   parameter int                FREQ_W      = 24,
   parameter int                HOLD_PERIOD = 16_384_000,
   parameter logic [FREQ_W-1:0] FREE_WORD   = '0,
   parameter bit                OUT_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [2:0]        mode_code,
   input  logic              lock_err,
   input  logic [FREQ_W-1:0] freq_in,
   input  logic              role_auto,
   input  logic              role_primary_req,
   input  logic              ref_err,
   output logic [1:0]        eff_mode,
   output logic [FREQ_W-1:0] freq_out,
   output logic              is_primary,
   output logic              promote
);
   timeunit 1ns;
   timeprecision 100ps;

   initial begin
      if (FREQ_W < 2)       $error("FREQ_W must be at least 2");
      if (HOLD_PERIOD < 2)  $error("HOLD_PERIOD must be at least 2");
   end

   eff_mode_t         mode_now;
   logic [FREQ_W-1:0] hold_word;
   logic [FREQ_W-1:0] freq_sel;

   mref_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_code (mode_code),
      .lock_err  (lock_err),
      .eff_mode  (mode_now)
   );

   mref_hold_store #(
      .FREQ_W      (FREQ_W),
      .HOLD_PERIOD (HOLD_PERIOD)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_en  (mode_now == MODE_NORMAL),
      .lock_err  (lock_err),
      .freq_in   (freq_in),
      .hold_word (hold_word)
   );

   mref_role_ctrl u_role (
      .clk              (clk),
      .rst_n            (rst_n),
      .role_auto        (role_auto),
      .role_primary_req (role_primary_req),
      .ref_err          (ref_err),
      .is_primary       (is_primary),
      .promote          (promote)
   );

   always_comb begin
      case (mode_now)
         MODE_HOLD: freq_sel = hold_word;
         MODE_FREE: freq_sel = FREE_WORD;
         default:   freq_sel = freq_in;
      endcase
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic [FREQ_W-1:0] freq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) freq_q <= '0;
            else        freq_q <= freq_sel;
         end
         assign freq_out = freq_q;
      end else begin : g_out_comb
         assign freq_out = freq_sel;
      end
   endgenerate

   assign eff_mode = mode_now;
endmodule

// File: rtl/mref_holdover_ctrl_chk.sv
module mref_holdover_ctrl_chk #(
   parameter int                FREQ_W    = 24,
   parameter logic [FREQ_W-1:0] FREE_WORD = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_wr,
   input logic [2:0]        mode_code,
   input logic [1:0]        eff_mode,
   input logic [FREQ_W-1:0] freq_out,
   input logic              role_auto,
   input logic              is_primary,
   input logic              promote
);
   timeunit 1ns;
   timeprecision 100ps;

   assert_hold_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_code == 3'b010) |=> (eff_mode == 2'd1));

   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode != 2'd0 && !mode_wr) |=> (eff_mode != 2'd0));

   assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode == 2'd1 && $past(eff_mode) == 2'd1 && !mode_wr) |=> $stable(freq_out));

   assert_free_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode == 2'd2 && $past(eff_mode) == 2'd2) |-> (freq_out == FREE_WORD));

   assert_promote_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      promote |-> (is_primary && !$past(is_primary)));

   assert_no_demote_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (role_auto && is_primary) |=> is_primary);
endmodule

bind mref_holdover_ctrl mref_holdover_ctrl_chk #(
   .FREQ_W    (FREQ_W),
   .FREE_WORD (FREE_WORD)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_wr    (mode_wr),
   .mode_code  (mode_code),
   .eff_mode   (eff_mode),
   .freq_out   (freq_out),
   .role_auto  (role_auto),
   .is_primary (is_primary),
   .promote    (promote)
);

// File: tb/sim_mref_holdover_ctrl.sv
module sim_mref_holdover_ctrl;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int          W    = 16;
   localparam int          P    = 8;
   localparam logic [W-1:0] FREE = 16'h8000;

   typedef struct packed {
      logic [1:0]   eff;
      logic [W-1:0] freq;
      logic         prim;
      logic         prom;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_wr = 1'b0;
   logic [2:0] mode_code = 3'b000;
   logic lock_err = 1'b0;
   logic [W-1:0] freq_in = 16'h0123;
   logic role_auto = 1'b0;
   logic role_req = 1'b0;
   logic ref_err = 1'b0;
   logic [1:0] eff_mode;
   logic [W-1:0] freq_out;
   logic is_primary;
   logic promote;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   exp_t  exp_q[$];
   string tag_q[$];

   logic [2:0]   m_prog = 3'b000;
   logic         m_fallen = 1'b0;
   int           m_cnt = 0;
   logic [W-1:0] m_hold = '0;
   logic         m_prim = 1'b0;
   logic         m_prom = 1'b0;

   always #2.5 clk = ~clk;

   mref_holdover_ctrl #(
      .FREQ_W(W), .HOLD_PERIOD(P), .FREE_WORD(FREE), .OUT_REG(1'b0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
      .lock_err(lock_err), .freq_in(freq_in), .role_auto(role_auto),
      .role_primary_req(role_req), .ref_err(ref_err), .eff_mode(eff_mode),
      .freq_out(freq_out), .is_primary(is_primary), .promote(promote)
   );

   function automatic logic [1:0] m_resolve(input logic [2:0] c, input logic f);
      if (c == 3'b010) return 2'd1;
      if (c == 3'b011) return 2'd2;
      if (c == 3'b110) return f ? 2'd1 : 2'd0;
      if (c == 3'b111) return f ? 2'd2 : 2'd0;
      return 2'd0;
   endfunction

   task automatic compare(input string tag, input exp_t x);
      checks++;
      if (eff_mode !== x.eff || freq_out !== x.freq ||
          is_primary !== x.prim || promote !== x.prom) begin
         errors++;
         $display("FAIL %s: actual eff=%0d freq=%h prim=%0b prom=%0b expected eff=%0d freq=%h prim=%0b prom=%0b",
                  tag, eff_mode, freq_out, is_primary, promote, x.eff, x.freq, x.prim, x.prom);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) compare(tag_q.pop_front(), exp_q.pop_front());
   end

   task automatic step(input string tag, input bit mw, input logic [2:0] code,
                       input bit le, input logic [W-1:0] fi,
                       input bit ra, input bit rq, input bit re);
      logic [1:0] e0;
      logic [1:0] e1;
      exp_t x;
      @(negedge clk);
      mode_wr = mw; mode_code = code; lock_err = le; freq_in = fi;
      role_auto = ra; role_req = rq; ref_err = re;
      e0 = m_resolve(m_prog, m_fallen);
      if (e0 == 2'd0) begin
         if (m_cnt == P - 1) begin
            if (!le) m_hold = fi;
            m_cnt = 0;
         end else m_cnt++;
      end else m_cnt = 0;
      if (mw) begin
         m_prog = code;
         if (code == 3'd0 || code == 3'd1 || code == 3'd4 || code == 3'd5) m_fallen = 1'b0;
      end else if (m_prog[2:1] == 2'b11 && le) m_fallen = 1'b1;
      if (!ra) begin m_prim = rq; m_prom = 1'b0; end
      else if (!m_prim && re) begin m_prim = 1'b1; m_prom = 1'b1; end
      else m_prom = 1'b0;
      e1 = m_resolve(m_prog, m_fallen);
      x.eff  = e1;
      x.freq = (e1 == 2'd0) ? fi : ((e1 == 2'd1) ? m_hold : FREE);
      x.prim = m_prim;
      x.prom = m_prom;
      exp_q.push_back(x);
      tag_q.push_back(tag);
      @(posedge clk);
   endtask

   task automatic mstep(input string tag, input bit mw, input logic [2:0] code,
                        input bit le, input logic [W-1:0] fi);
      step(tag, mw, code, le, fi, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #5000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      exp_t r;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      r.eff = 2'd0; r.freq = 16'h0123; r.prim = 1'b0; r.prom = 1'b0;
      compare("R1 reset state", r);

      mstep("R1 R2 hold shows zero stored word", 1, 3'b010, 0, 16'h0AAA);
      mstep("R2 free run", 1, 3'b011, 0, 16'h0BBB);
      mstep("R2 reserved 001 is normal", 1, 3'b001, 0, 16'h0CCC);
      mstep("R2 reserved 100 is normal", 1, 3'b100, 0, 16'h0CCD);
      mstep("R2 reserved 101 is normal", 1, 3'b101, 0, 16'h0CCE);
      mstep("R2 explicit normal", 1, 3'b000, 0, 16'h0CCF);
      for (int i = 0; i < 20; i++)
         mstep("R5 R6 normal passthrough", 0, 3'b000, 0, W'(16'h0100 + i * 3));
      mstep("R5 R6 hold shows last capture", 1, 3'b010, 0, 16'h7777);
      for (int i = 0; i < 5; i++)
         mstep("R6 hold ignores freq_in", 0, 3'b010, 0, W'(16'h2000 + i));
      mstep("R3 lock error ignored in explicit normal", 1, 3'b000, 1, 16'h0400);
      for (int i = 0; i < 10; i++)
         mstep("R3 R5 normal under lock error", 0, 3'b000, 1, 16'hDEAD);
      mstep("R5 capture skipped under lock error", 1, 3'b010, 0, 16'h0500);

      mstep("R3 auto hold armed", 1, 3'b110, 0, 16'h0600);
      for (int i = 0; i < 3; i++)
         mstep("R3 auto hold stays normal", 0, 3'b110, 0, W'(16'h0610 + i));
      mstep("R3 auto hold falls back", 0, 3'b110, 1, 16'h0620);
      for (int i = 0; i < 3; i++)
         mstep("R4 fallback persists", 0, 3'b110, 0, W'(16'h0630 + i));
      mstep("R4 other code keeps fallback", 1, 3'b010, 0, 16'h0640);
      mstep("R4 auto free with fallback kept", 1, 3'b111, 0, 16'h0650);
      mstep("R4 rewrite auto keeps fallback", 1, 3'b110, 0, 16'h0655);
      mstep("R4 reserved write clears", 1, 3'b100, 0, 16'h0660);
      mstep("R3 auto free armed", 1, 3'b111, 0, 16'h0670);
      mstep("R3 auto free falls back", 0, 3'b111, 1, 16'h0680);
      mstep("R4 normal write clears", 1, 3'b000, 0, 16'h0690);

      for (int i = 0; i < 12; i++)
         mstep("R9 settle in normal", 0, 3'b000, 0, W'(16'h1000 + i));
      mstep("R9 enter hold", 1, 3'b010, 0, 16'h1100);
      mstep("R9 hold during reference swap", 0, 3'b010, 0, 16'h1101);
      mstep("R9 return to normal", 1, 3'b000, 0, 16'h2222);
      for (int i = 0; i < P - 2; i++)
         mstep("R9 no capture yet", 0, 3'b000, 0, 16'h3333);
      mstep("R9 one edge early keeps old word", 1, 3'b010, 0, 16'h3334);
      mstep("R9 back to normal", 1, 3'b000, 0, 16'h2223);
      for (int i = 0; i < P - 1; i++)
         mstep("R9 counting", 0, 3'b000, 0, 16'h3335);
      mstep("R9 capture on interval edge", 1, 3'b010, 0, 16'h4444);
      mstep("R6 back to normal", 1, 3'b000, 0, 16'h4445);

      step("R8 manual to primary", 0, 3'b000, 0, 16'h5000, 0, 1, 0);
      step("R8 manual to secondary", 0, 3'b000, 0, 16'h5001, 0, 0, 0);
      step("R7 auto no error stays secondary", 0, 3'b000, 0, 16'h5002, 1, 1, 0);
      step("R7 auto promotion", 0, 3'b000, 0, 16'h5003, 1, 0, 1);
      step("R7 promote flag one cycle", 0, 3'b000, 0, 16'h5004, 1, 0, 1);
      step("R8 auto ignores request", 0, 3'b000, 0, 16'h5005, 1, 0, 0);
      step("R8 manual returns secondary", 0, 3'b000, 0, 16'h5006, 0, 0, 0);
      step("R7 R8 manual ignores ref error", 0, 3'b000, 0, 16'h5007, 0, 0, 1);

      @(negedge clk);
      mode_wr = 1'b0;
      @(posedge clk);
      #2;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule